// File: doc/BRIEF.md
# Camera Control Serial Port

This block is a full-duplex asynchronous serial port for the control channel of a camera. It runs on a 40 MHz system clock, and every host-side signal is synchronous to that clock. Frames carry one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. Both directions run at the same rate. The host picks that rate from eight standard values with a one-hot code.

On the host side there are three handshakes:
- **Rate change:** a four-phase request/acknowledge exchange.
- **Transmit:** a one-cycle write strobe, accepted only while the transmitter reports that it is ready.
- **Receive:** a two-cycle read strobe that pops one entry from a 16-entry receive buffer.

Each buffered entry carries its byte together with a break flag and a framing-error flag. A separate overrun flag reports that a byte was lost because the buffer was full.

Top module: `serial_ctl_uart`

## Requirements
- R1: After reset, `uart_txd` is 1, `tx_ready` is 1, `rx_ready` is 0, `baud_ack` is 0, `rx_overrun` is 0, `rx_data`/`rx_break`/`rx_frame_err` are 0, and the rate is 9600 baud.
- R2: Code bit i (codes 1, 2, 4, 8, 16, 32, 64, 128) selects 9600, 19200, 38400, 57600, 115200, 230400, 460800 and 921600 baud. The divisor is round(CLK_HZ / (16 x baud)), and each transmitted bit lasts exactly 16 x divisor clock cycles.
- R3: While `baud_set` is high and `baud_ack` is low, `baud_ack` rises on the next clock and the code is loaded. `baud_ack` stays high until `baud_set` is seen low, then falls on the next clock. A code that is not one-hot is still acknowledged but leaves the rate unchanged.
- R4: A `tx_wr` strobe while `tx_ready` is 1 sends one frame: a low start bit, then `tx_data` bits 0 to 7, then a high stop bit. `tx_ready` is 0 from the cycle after the strobe until the stop bit has lasted a full bit time, and the line is high whenever `tx_ready` is 1.
- R5: A `tx_wr` strobe while `tx_ready` is 0 is ignored. It changes neither the frame in flight nor anything after it.
- R6: The receiver finds each start bit and samples each bit near its middle using 16 ticks per bit. It stores each 8N1 byte in the buffer. `rx_ready` is 1 exactly while the buffer holds at least one entry.
- R7: A rising `rx_rd`, with `rx_rd` held high for two cycles, pops one entry. Its byte and flags appear on `rx_data`/`rx_break`/`rx_frame_err` only during the second high cycle and are 0 at all other times. A read while the buffer is empty returns zeros and changes nothing.
- R8: A stop bit sampled low after a nonzero byte stores that byte with `rx_frame_err` = 1 and `rx_break` = 0.
- R9: A line held low through the stop-bit sample with all data bits 0 stores byte 0 with `rx_break` = 1 and `rx_frame_err` = 0. The receiver then waits for the line to return high before it looks for the next start bit.
- R10: The buffer holds 16 entries in arrival order. A byte that arrives while it is full is dropped and `rx_overrun` goes to 1. The next read that pops an entry clears `rx_overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (40 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_code | input | 8 | One-hot rate code |
| baud_set | input | 1 | Rate-change request |
| baud_ack | output | 1 | Rate-change acknowledge |
| tx_data | input | 8 | Byte to transmit |
| tx_wr | input | 1 | One-cycle transmit strobe |
| tx_ready | output | 1 | Transmitter can accept a byte |
| rx_rd | input | 1 | Two-cycle read strobe |
| rx_ready | output | 1 | Receive buffer not empty |
| rx_data | output | 8 | Read byte, valid in second read cycle |
| rx_break | output | 1 | Entry being read was a break |
| rx_frame_err | output | 1 | Entry being read had a bad stop bit |
| rx_overrun | output | 1 | A received byte was dropped |
| uart_txd | output | 1 | Serial transmit line |
| uart_rxd | input | 1 | Serial receive line |

## Verification
The bench sweeps the reset rate and every one-hot code. For each, it measures the start-bit width in cycles against a divisor computed with real arithmetic. A rounding or table error would therefore show up as a width off by a multiple of 16 cycles. It also drives a non-one-hot code, which a careless decoder would turn into a zero or merged divisor, and it injects a write strobe in the middle of a frame, which a loose ready gate would let corrupt the shift register or queue a second frame. On the receive side it sends an all-zero byte with a good stop bit, which must not be taken for a break, a bad stop bit, and a long low break. It then fills the buffer to 17 bytes, which exposes off-by-one full logic, lost ordering and an overrun flag that never clears. Reads check the data window cycle by cycle, so data that arrives a cycle early or lingers would be caught.

// File: rtl/scu_pkg.sv
package scu_pkg;

  localparam int unsigned OVS = 16;
  localparam int unsigned NUM_RATES = 8;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic [7:0] data;
  } rx_word_t;

  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD} rx_state_e;

  // rate selected by one-hot code bit idx
  function automatic int unsigned baud_of_idx(int unsigned idx);
    case (idx)
      0: return 9600;
      1: return 19200;
      2: return 38400;
      3: return 57600;
      4: return 115200;
      5: return 230400;
      6: return 460800;
      default: return 921600;
    endcase
  endfunction

  // clocks per oversampling tick, rounded to nearest
  function automatic int unsigned divisor_for(int unsigned clk_hz, int unsigned baud);
    return (clk_hz + (OVS * baud) / 2) / (OVS * baud);
  endfunction

endpackage

// File: rtl/scu_baud_gen.sv
module scu_baud_gen
  import scu_pkg::*;
#(
  parameter int unsigned CLK_HZ = 40_000_000,
  parameter int unsigned DIV_W  = 9,
  parameter int unsigned CYC_W  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       baud_code,
  input  logic             baud_set,
  output logic             baud_ack,
  output logic             tick,
  output logic [CYC_W-1:0] bit_cycles
);

  localparam int unsigned OVS_W = $clog2(OVS);

  logic [DIV_W-1:0] div_tab [NUM_RATES];
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] sel_div;
  logic [DIV_W-1:0] tcnt;
  logic             code_valid;
  logic             load_evt;
  logic             release_evt;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    localparam int unsigned D = divisor_for(CLK_HZ, baud_of_idx(g));
    assign div_tab[g] = DIV_W'(D);
  end

  always_comb begin
    sel_div = div_q;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (baud_code[i]) sel_div = div_tab[i];
    end
  end

  assign code_valid  = $onehot(baud_code);
  assign load_evt    = baud_set && !baud_ack;
  assign release_evt = !baud_set && baud_ack;
  assign tick        = (tcnt == div_q - 1'b1);
  assign bit_cycles  = CYC_W'(div_q) << OVS_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baud_ack <= 1'b0;
      div_q    <= div_tab[0];
      tcnt     <= '0;
    end else begin
      if (load_evt) begin
        baud_ack <= 1'b1;
        tcnt     <= '0;
        if (code_valid) div_q <= sel_div;
      end else begin
        if (release_evt) baud_ack <= 1'b0;
        tcnt <= tick ? '0 : tcnt + 1'b1;
      end
    end
  end

  a_r3_ack_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_set && !baud_ack) |=> baud_ack);
  a_r3_ack_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_set && baud_ack) |=> !baud_ack);
  a_r3_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_set && baud_ack) |=> baud_ack);
  a_r3_bad_code_keeps_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_set && !baud_ack && !$onehot(baud_code)) |=> $stable(bit_cycles));
  a_r2_rate_only_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(baud_set && !baud_ack) |=> $stable(bit_cycles));

endmodule

// File: rtl/scu_tx.sv
module scu_tx
  import scu_pkg::*;
#(
  parameter int unsigned CYC_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CYC_W-1:0] bit_cycles,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             txd
);

  tx_state_e        state;
  logic [CYC_W-1:0] cnt;
  logic [7:0]       shreg;
  logic [2:0]       bitn;
  logic             bit_end;

  assign bit_end  = (cnt == bit_cycles - 1'b1);
  assign tx_ready = (state == TX_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      cnt   <= '0;
      shreg <= '0;
      bitn  <= '0;
      txd   <= 1'b1;
    end else begin
      cnt <= bit_end ? '0 : cnt + 1'b1;
      case (state)
        TX_IDLE: begin
          cnt <= '0;
          if (tx_wr) begin
            shreg <= tx_data;
            state <= TX_START;
            txd   <= 1'b0;
          end
        end
        TX_START: begin
          if (bit_end) begin
            state <= TX_DATA;
            bitn  <= '0;
            txd   <= shreg[0];
          end
        end
        TX_DATA: begin
          if (bit_end) begin
            shreg <= shreg >> 1;
            if (bitn == 3'd7) begin
              state <= TX_STOP;
              txd   <= 1'b1;
            end else begin
              bitn <= bitn + 1'b1;
              txd  <= shreg[1];
            end
          end
        end
        TX_STOP: begin
          if (bit_end) state <= TX_IDLE;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  a_r4_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_ready) |=> (!tx_ready && !txd));
  a_r4_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);
  a_r5_busy_write_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && state == TX_DATA) |=> (state != TX_START));

endmodule

// File: rtl/scu_rx.sv
module scu_rx
  import scu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     rxd,
  output logic     push,
  output rx_word_t push_word
);

  localparam int unsigned OVS_W = $clog2(OVS);
  localparam logic [OVS_W-1:0] MID_TICK = OVS_W'(OVS / 2 - 1);
  localparam logic [OVS_W-1:0] END_TICK = OVS_W'(OVS - 1);

  rx_state_e        state;
  logic             rx_meta;
  logic             rxs;
  logic [OVS_W-1:0] cnt;
  logic [2:0]       bitn;
  logic [7:0]       shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_meta <= 1'b1;
      rxs     <= 1'b1;
    end else begin
      rx_meta <= rxd;
      rxs     <= rx_meta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      shreg     <= '0;
      push      <= 1'b0;
      push_word <= '0;
    end else begin
      push <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (tick && !rxs) begin
            state <= RX_START;
            cnt   <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (cnt == MID_TICK) begin
              cnt   <= '0;
              bitn  <= '0;
              state <= rxs ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (cnt == END_TICK) begin
              cnt   <= '0;
              shreg <= {rxs, shreg[7:1]};
              if (bitn == 3'd7) state <= RX_STOP;
              else bitn <= bitn + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (cnt == END_TICK) begin
              cnt            <= '0;
              push           <= 1'b1;
              push_word.data <= shreg;
              push_word.brk  <= !rxs && (shreg == 8'h00);
              push_word.ferr <= !rxs && (shreg != 8'h00);
              state          <= rxs ? RX_IDLE : RX_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_HOLD: begin
          if (rxs) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  a_r9_hold_until_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_HOLD && !rxs) |=> (state == RX_HOLD));
  a_r6_push_single: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);

endmodule

// File: rtl/scu_rx_fifo.sv
module scu_rx_fifo
  import scu_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  rx_word_t push_word,
  input  logic     pop,
  output rx_word_t head,
  output logic     empty,
  output logic     overrun
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  rx_word_t        mem [DEPTH];
  logic [AW-1:0]   wp;
  logic [AW-1:0]   rp;
  logic [CW-1:0]   cnt;
  logic            full;
  logic            do_pop;
  logic            accept;
  logic            drop;

  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign do_pop = pop && !empty;
  assign accept = push && (!full || do_pop);
  assign drop   = push && full && !do_pop;
  assign head   = mem[rp];

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      overrun <= 1'b0;
    end else begin
      if (accept) wp <= wp + 1'b1;
      if (do_pop) rp <= rp + 1'b1;
      cnt <= cnt + CW'(accept) - CW'(do_pop);
      if (drop) overrun <= 1'b1;
      else if (do_pop) overrun <= 1'b0;
    end
  end

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r10_drop_sets_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> overrun);
  a_r10_full_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
  a_r9_break_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_word.brk) |-> (push_word.data == 8'h00 && !push_word.ferr));

endmodule

// File: rtl/serial_ctl_uart.sv
module serial_ctl_uart
  import scu_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 40_000_000,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] baud_code,
  input  logic       baud_set,
  output logic       baud_ack,
  input  logic [7:0] tx_data,
  input  logic       tx_wr,
  output logic       tx_ready,
  input  logic       rx_rd,
  output logic       rx_ready,
  output logic [7:0] rx_data,
  output logic       rx_break,
  output logic       rx_frame_err,
  output logic       rx_overrun,
  output logic       uart_txd,
  input  logic       uart_rxd
);

  localparam int unsigned DIV_W = $clog2(divisor_for(CLK_HZ, baud_of_idx(0)) + 1);
  localparam int unsigned CYC_W = DIV_W + $clog2(OVS);

  logic             tick;
  logic [CYC_W-1:0] bit_cycles;
  logic             rx_push;
  rx_word_t         rx_push_word;
  rx_word_t         fifo_head;
  logic             fifo_empty;
  logic             rd_q;
  logic             rd_rise;
  rx_word_t         rd_out;

  scu_baud_gen #(.CLK_HZ(CLK_HZ), .DIV_W(DIV_W), .CYC_W(CYC_W)) u_baud (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_code  (baud_code),
    .baud_set   (baud_set),
    .baud_ack   (baud_ack),
    .tick       (tick),
    .bit_cycles (bit_cycles)
  );

  scu_tx #(.CYC_W(CYC_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_cycles (bit_cycles),
    .tx_wr      (tx_wr),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .txd        (uart_txd)
  );

  scu_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .rxd       (uart_rxd),
    .push      (rx_push),
    .push_word (rx_push_word)
  );

  scu_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_push),
    .push_word (rx_push_word),
    .pop       (rd_rise),
    .head      (fifo_head),
    .empty     (fifo_empty),
    .overrun   (rx_overrun)
  );

  assign rd_rise = rx_rd && !rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      rd_out <= '0;
    end else begin
      rd_q   <= rx_rd;
      rd_out <= (rd_rise && !fifo_empty) ? fifo_head : '0;
    end
  end

  assign rx_ready     = !fifo_empty;
  assign rx_data      = rd_out.data;
  assign rx_break     = rd_out.brk;
  assign rx_frame_err = rd_out.ferr;

  a_r7_data_only_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_out != '0) |-> ($past(rx_rd) && !$past(rd_q)));
  a_r7_window_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rd_q) |=> (rd_out == '0));

endmodule

// File: tb/test_serial_ctl_uart.sv
module test_serial_ctl_uart;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] baud_code;
  logic       baud_set;
  logic       baud_ack;
  logic [7:0] tx_data;
  logic       tx_wr;
  logic       tx_ready;
  logic       rx_rd;
  logic       rx_ready;
  logic [7:0] rx_data;
  logic       rx_break;
  logic       rx_frame_err;
  logic       rx_overrun;
  logic       uart_txd;
  logic       uart_rxd;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  serial_ctl_uart i_serial_ctl_uart (
    .clk(clk), .rst_n(rst_n), .baud_code(baud_code), .baud_set(baud_set),
    .baud_ack(baud_ack), .tx_data(tx_data), .tx_wr(tx_wr), .tx_ready(tx_ready),
    .rx_rd(rx_rd), .rx_ready(rx_ready), .rx_data(rx_data), .rx_break(rx_break),
    .rx_frame_err(rx_frame_err), .rx_overrun(rx_overrun), .uart_txd(uart_txd),
    .uart_rxd(uart_rxd)
  );

  function automatic int rate_of(int idx);
    int r;
    r = 9600;
    if (idx >= 1) r = 19200;
    if (idx >= 2) r = 38400;
    if (idx >= 3) r = 57600;
    if (idx >= 4) r = 115200 << (idx - 4);
    return r;
  endfunction

  function automatic int bit_time(int baud);
    return 16 * $rtoi(40.0e6 / (16.0 * baud) + 0.5);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic handshake(input logic [7:0] code);
    @(negedge clk);
    baud_code = code;
    baud_set  = 1'b1;
    @(negedge clk);
    chk(baud_ack === 1'b1, "R3 ack rises", int'(baud_ack), 1);
    baud_set = 1'b0;
    @(negedge clk);
    chk(baud_ack === 1'b0, "R3 ack falls", int'(baud_ack), 0);
  endtask

  // send v (odd) and check width, bits and ready timing
  task automatic tx_frame(input logic [7:0] v, input int bc, input bit inject, input string tag);
    int n;
    int p;
    int target;
    logic expb;
    bit stayed;
    @(negedge clk);
    tx_data = v;
    tx_wr   = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    chk(tx_ready === 1'b0, {"R4 busy after strobe ", tag}, int'(tx_ready), 0);
    n = 0;
    while (uart_txd === 1'b0 && n < 10000) begin
      n++;
      @(negedge clk);
    end
    chk(n == bc, {"R2 start bit width ", tag}, n, bc);
    p = 0;
    for (int k = 0; k < 9; k++) begin
      target = k * bc + bc / 2;
      repeat (target - p) @(negedge clk);
      p = target;
      expb = (k < 8) ? v[k] : 1'b1;
      chk(uart_txd === expb, {"R4 frame bit ", tag}, int'(uart_txd), int'(expb));
      if (inject && k == 2) begin
        tx_data = 8'hFF;
        tx_wr   = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        p++;
        chk(tx_ready === 1'b0, "R5 still busy after ignored strobe", int'(tx_ready), 0);
      end
    end
    repeat (9 * bc - 1 - p) @(negedge clk);
    chk(tx_ready === 1'b0, {"R4 busy through stop ", tag}, int'(tx_ready), 0);
    @(negedge clk);
    chk(tx_ready === 1'b1, {"R4 ready after stop ", tag}, int'(tx_ready), 1);
    if (inject) begin
      stayed = 1'b1;
      repeat (2 * bc) begin
        @(negedge clk);
        if (uart_txd !== 1'b1) stayed = 1'b0;
      end
      chk(stayed, "R5 no queued frame", int'(stayed), 1);
    end
  endtask

  task automatic send_rx(input logic [7:0] v, input logic stopb, input int bc);
    @(negedge clk);
    uart_rxd = 1'b0;
    repeat (bc) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      uart_rxd = v[k];
      repeat (bc) @(negedge clk);
    end
    uart_rxd = stopb;
    repeat (bc) @(negedge clk);
    uart_rxd = 1'b1;
    repeat (bc) @(negedge clk);
  endtask

  task automatic read_entry(output int d, output int b, output int f);
    @(negedge clk);
    chk(rx_data === 8'h00, "R7 data zero before read", int'(rx_data), 0);
    rx_rd = 1'b1;
    @(negedge clk);
    d = int'(rx_data);
    b = int'(rx_break);
    f = int'(rx_frame_err);
    @(negedge clk);
    rx_rd = 1'b0;
    chk(rx_data === 8'h00 && rx_break === 1'b0, "R7 data zero after window", int'(rx_data), 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int d;
    int b;
    int f;
    int bc;
    logic [7:0] pats [6];
    pats = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h01, 8'h80};
    rst_n = 1'b0;
    baud_code = 8'h00;
    baud_set = 1'b0;
    tx_data = 8'h00;
    tx_wr = 1'b0;
    rx_rd = 1'b0;
    uart_rxd = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(uart_txd === 1'b1, "R1 txd idle", int'(uart_txd), 1);
    chk(tx_ready === 1'b1, "R1 tx_ready", int'(tx_ready), 1);
    chk(rx_ready === 1'b0, "R1 rx_ready", int'(rx_ready), 0);
    chk(baud_ack === 1'b0, "R1 baud_ack", int'(baud_ack), 0);
    chk(rx_overrun === 1'b0, "R1 overrun", int'(rx_overrun), 0);
    chk(rx_data === 8'h00 && rx_break === 1'b0 && rx_frame_err === 1'b0,
        "R1 read outputs", int'(rx_data), 0);

    // R1 reset rate is 9600
    tx_frame(8'hA5, bit_time(rate_of(0)), 1'b0, "R1 reset rate");

    // R2 sweep of the remaining one-hot codes
    for (int i = 1; i < 8; i++) begin
      handshake(8'(1 << i));
      tx_frame(8'(8'h3B ^ (i << 2)) | 8'h01, bit_time(rate_of(i)), 1'b0, "R2 sweep");
    end

    // R3 non one-hot code keeps 921600
    handshake(8'h03);
    tx_frame(8'h69, bit_time(rate_of(7)), 1'b0, "R3 bad code");
    handshake(8'h00);
    tx_frame(8'h97, bit_time(rate_of(7)), 1'b0, "R3 zero code");

    // R5 write strobe in mid frame
    tx_frame(8'hC3, bit_time(rate_of(7)), 1'b1, "R5 inject");

    bc = bit_time(rate_of(7));

    // R7 read on empty buffer
    read_entry(d, b, f);
    chk(d == 0 && b == 0 && f == 0, "R7 empty read zeros", d, 0);
    chk(rx_ready === 1'b0, "R7 empty read no change", int'(rx_ready), 0);

    // R6 plain bytes
    foreach (pats[i]) begin
      send_rx(pats[i], 1'b1, bc);
      chk(rx_ready === 1'b1, "R6 rx_ready after byte", int'(rx_ready), 1);
      read_entry(d, b, f);
      chk(d == int'(pats[i]), "R6 rx byte", d, int'(pats[i]));
      chk(b == 0 && f == 0, "R6 flags clear", b * 2 + f, 0);
      chk(rx_ready === 1'b0, "R6 rx_ready after read", int'(rx_ready), 0);
    end

    // R8 framing error
    send_rx(8'h5A, 1'b0, bc);
    read_entry(d, b, f);
    chk(d == 8'h5A, "R8 ferr byte kept", d, 8'h5A);
    chk(f == 1 && b == 0, "R8 ferr flag", f * 2 + b, 2);

    // R9 break
    @(negedge clk);
    uart_rxd = 1'b0;
    repeat (12 * bc) @(negedge clk);
    uart_rxd = 1'b1;
    repeat (2 * bc) @(negedge clk);
    chk(rx_ready === 1'b1, "R9 break entry stored", int'(rx_ready), 1);
    read_entry(d, b, f);
    chk(d == 0 && b == 1 && f == 0, "R9 break flag and zero byte", d * 4 + b * 2 + f, 2);
    chk(rx_ready === 1'b0, "R9 only one break entry", int'(rx_ready), 0);
    send_rx(8'h96, 1'b1, bc);
    read_entry(d, b, f);
    chk(d == 8'h96 && b == 0 && f == 0, "R9 byte after break", d, 8'h96);

    // R10 fill, overflow, order
    for (int i = 0; i < 17; i++) begin
      send_rx(8'((i * 37 + 5) & 255), 1'b1, bc);
      if (i == 15) chk(rx_overrun === 1'b0, "R10 no overrun at 16", int'(rx_overrun), 0);
    end
    chk(rx_overrun === 1'b1, "R10 overrun on 17th", int'(rx_overrun), 1);
    for (int i = 0; i < 16; i++) begin
      read_entry(d, b, f);
      chk(d == ((i * 37 + 5) & 255), "R10 order", d, (i * 37 + 5) & 255);
      if (i == 0) chk(rx_overrun === 1'b0, "R10 overrun cleared by read", int'(rx_overrun), 0);
    end
    chk(rx_ready === 1'b0, "R10 17th byte dropped", int'(rx_ready), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule